// File: doc/BRIEF.md
# Sleep, Wake and Offset Calibration Controller

This block decides whether a charge-counting front end runs, sleeps or measures its own input offset. It watches three things: the level of a single-wire serial data line, a comparator result saying whether the magnitude of the sensed signal is above a programmable threshold, and a small mode register written by the host. From these it drives a wake request, which is active low and otherwise released. It also produces a counting enable for the accumulators and an 8-bit two's-complement offset register.

All timing is counted in ticks of a prescaled clock. The sleep qualification time and the calibration window length are parameters, so a fast bench can shorten them. While the window is open, an up/down accumulator starts from zero. On each tick it steps up or down by one according to the polarity of the offset sample, and it saturates at both ends. When the window completes without interruption, the result is latched into the offset register.

The threshold is held as a 3-bit code and passed on to an external comparator. The magnitude it selects is a fixed reference divided by the code.

Top module: `wake_cal_ctrl`

## Requirements
- R1: `wakeLow` is 1 one clock after an edge at which `lineIn` was 1 and `sigAbove` was 1, and 0 after any other edge (1 means the wake line is pulled low, 0 means it is released).
- R2: With calibration not pending, `countEn` drops to 0 only after the line has been low with `sigAbove` 0 for more than SLEEP_TICKS consecutive ticks. `countEn` is 1 in the operating state and 0 in the sleep, calibration and post-calibration states.
- R3: From sleep, the edge at which `lineIn` is 1 returns the block to operation, so `countEn` reads 1 one clock later.
- R4: `threshCode` resets to 7. A mode write with a code of 1 to 7 loads it, and a write with code 0 leaves it unchanged.
- R5: With `calPending` set and the override clear, the quiet condition that would lead to sleep (line low, below threshold, for more than SLEEP_TICKS ticks) opens a calibration window instead.
- R6: In the window the accumulator starts at 0 and steps +1 on each tick with `offDir`=1, or -1 with `offDir`=0, saturating at +127 and -128. On the CAL_TICKS-th tick the stepped value is loaded into `offsetOut` and `calPending` clears. `offsetOut` is 0 after reset and changes at no other time.
- R7: In the window, `sigAbove`=1, or `lineIn`=1 with the override clear, returns the block to operation and discards the partial result. The next window restarts from zero, and `calPending` stays set.
- R8: After a completed window, `countEn` stays 0 until an edge at which `lineIn` is 1.
- R9: With `calPending` and `ovrPending` both set, a window opens at the first edge with `sigAbove`=0, whatever the line level. The line being high does not abort it, and completion clears `ovrPending`.
- R10: A mode write (`modeWr`=1) loads `calPending` from `modeCalIn` and `ovrPending` from `modeOvrIn` at the next edge. A completion at the same edge takes priority and clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Synchronized level of the serial data line |
| sigAbove | input | 1 | Comparator: signal magnitude above threshold |
| offDir | input | 1 | Polarity of the offset sample (1 = up) |
| modeWr | input | 1 | Mode register write strobe |
| modeCalIn | input | 1 | Calibration request bit to write |
| modeOvrIn | input | 1 | Line-low override bit to write |
| modeCodeIn | input | 3 | Threshold code to write (0 ignored) |
| wakeLow | output | 1 | 1 = pull wake line low, 0 = released |
| countEn | output | 1 | Enable for the charge and time accumulators |
| offsetOut | output | 8 | Latched offset, two's complement |
| calPending | output | 1 | Calibration requested and not yet completed |
| ovrPending | output | 1 | Line-low requirement overridden |
| threshCode | output | 3 | Threshold code sent to the comparator |

## Verification
The assertions take `lineIn`, `sigAbove` and `offDir` to be synchronous to `clk` and settled at every rising edge. They also take it that `modeWr` and its data fields are presented together for a single edge. The bench drives every input on the falling edge so that this holds. Its random segments keep the line low for long stretches and keep the comparator quiet most of the time, so windows open, complete and abort many times. Mode writes arrive in the middle of windows, including codes of 0 and writes that set the override alone.

// File: rtl/wake_cal_pkg.sv
package wake_cal_pkg;
  localparam int OFF_W = 8;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_CAL   = 2'd2,
    ST_DONE  = 2'd3
  } pwr_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic winClr;
    logic winStep;
    logic commit;
  } win_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic tick;
    logic quietLong;
    logic calLast;
    logic calPend;
    logic ovrPend;
  } win_status_t;
endpackage

// File: rtl/wake_cal_tick.sv
module wake_cal_tick #(
  parameter int TICK_DIV = 1024
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) divCnt <= '0;
        else if (divCnt == DW'(TICK_DIV - 1)) divCnt <= '0;
        else divCnt <= divCnt + DW'(1);
      end
      assign tick = (divCnt == DW'(TICK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/wake_cal_fsm.sv
module wake_cal_fsm
  import wake_cal_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineIn,
  input  logic        sigAbove,
  input  win_status_t stat,
  output win_strobe_t strb,
  output logic        countEn
);
  pwr_state_e stateQ, stateD;
  logic quietNow;

  assign quietNow = !lineIn && !sigAbove;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_RUN: begin
        strb.winClr = 1'b1;
        if (stat.calPend && (stat.ovrPend ? !sigAbove : (quietNow && stat.quietLong)))
          stateD = ST_CAL;
        else if (!stat.calPend && quietNow && stat.quietLong)
          stateD = ST_SLEEP;
      end
      ST_SLEEP: begin
        strb.winClr = 1'b1;
        if (lineIn) stateD = ST_RUN;
      end
      ST_CAL: begin
        if (sigAbove || (!stat.ovrPend && lineIn)) begin
          strb.winClr = 1'b1;
          stateD      = ST_RUN;
        end else if (stat.tick) begin
          if (stat.calLast) begin
            strb.commit = 1'b1;
            stateD      = ST_DONE;
          end else begin
            strb.winStep = 1'b1;
          end
        end
      end
      ST_DONE: begin
        strb.winClr = 1'b1;
        if (lineIn) stateD = ST_RUN;
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else stateQ <= stateD;
  end

  assign countEn = (stateQ == ST_RUN);

  // R2: sleep is only ever entered from a quiet line with no calibration pending
  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SLEEP && $past(stateQ) == ST_RUN) |-> $past(!lineIn && !sigAbove && !stat.calPend))
    else $error("sleep entered without quiet line");

  // R3: sleep persists while the line stays low
  a_r3_sleep_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SLEEP && !lineIn) |=> stateQ == ST_SLEEP)
    else $error("sleep left with line low");

  // R7: signal above threshold aborts the window
  a_r7_abort_above: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CAL && sigAbove) |=> stateQ == ST_RUN)
    else $error("window not aborted");

  // R8: post-calibration low power holds while line low
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DONE && !lineIn) |=> stateQ == ST_DONE)
    else $error("low power left with line low");
endmodule

// File: rtl/wake_cal_dp.sv
module wake_cal_dp
  import wake_cal_pkg::*;
#(
  parameter int SLEEP_TICKS = 10,
  parameter int CAL_TICKS   = 3600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  logic              sigAbove,
  input  logic              offDir,
  input  logic              tick,
  input  win_strobe_t       strb,
  input  logic              modeWr,
  input  logic              modeCalIn,
  input  logic              modeOvrIn,
  input  logic [CODE_W-1:0] modeCodeIn,
  output win_status_t       stat,
  output logic              wakeLow,
  output logic [OFF_W-1:0]  offsetOut,
  output logic              calPending,
  output logic              ovrPending,
  output logic [CODE_W-1:0] threshCode
);
  localparam int LW = $clog2(SLEEP_TICKS + 1);
  localparam int CW = (CAL_TICKS > 2) ? $clog2(CAL_TICKS) : 1;
  localparam logic signed [OFF_W-1:0] OFF_MAX = {1'b0, {(OFF_W-1){1'b1}}};
  localparam logic signed [OFF_W-1:0] OFF_MIN = {1'b1, {(OFF_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] CODE_RST = {CODE_W{1'b1}};

  logic [LW-1:0] lowCnt;
  logic [CW-1:0] calCnt;
  logic signed [OFF_W-1:0] accQ, accStep, offQ;
  logic calQ, ovrQ, wakeQ;
  logic [CODE_W-1:0] codeQ;
  logic quietNow;

  assign quietNow = !lineIn && !sigAbove;

  // quiet-time counter, saturating at the sleep limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else if (!quietNow) lowCnt <= '0;
    else if (tick && lowCnt != LW'(SLEEP_TICKS)) lowCnt <= lowCnt + LW'(1);
  end

  // saturating up/down step
  always_comb begin
    if (offDir) accStep = (accQ == OFF_MAX) ? accQ : accQ + OFF_W'(1);
    else        accStep = (accQ == OFF_MIN) ? accQ : accQ - OFF_W'(1);
  end

  // window counter and accumulator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calCnt <= '0;
      accQ   <= '0;
    end else if (strb.winClr || strb.commit) begin
      calCnt <= '0;
      accQ   <= '0;
    end else if (strb.winStep) begin
      calCnt <= calCnt + CW'(1);
      accQ   <= accStep;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) offQ <= '0;
    else if (strb.commit) offQ <= accStep;
  end

  // mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calQ  <= 1'b0;
      ovrQ  <= 1'b0;
      codeQ <= CODE_RST;
    end else begin
      if (modeWr) begin
        calQ <= modeCalIn;
        ovrQ <= modeOvrIn;
        if (modeCodeIn != '0) codeQ <= modeCodeIn;
      end
      if (strb.commit) begin
        calQ <= 1'b0;
        ovrQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeQ <= 1'b0;
    else wakeQ <= lineIn && sigAbove;
  end

  assign stat.tick      = tick;
  assign stat.quietLong = (lowCnt == LW'(SLEEP_TICKS));
  assign stat.calLast   = (calCnt == CW'(CAL_TICKS - 1));
  assign stat.calPend   = calQ;
  assign stat.ovrPend   = ovrQ;

  assign wakeLow    = wakeQ;
  assign offsetOut  = offQ;
  assign calPending = calQ;
  assign ovrPending = ovrQ;
  assign threshCode = codeQ;

  // R1: wake pulled low only after line high and signal above
  a_r1_wake_cause: assert property (@(posedge clk) disable iff (!rstN)
    wakeQ |-> $past(lineIn && sigAbove))
    else $error("wake without cause");

  // R4: threshold code never becomes zero
  a_r4_code_valid: assert property (@(posedge clk) disable iff (!rstN)
    codeQ != '0)
    else $error("threshold code zero");

  // R6: offset register only moves on completion
  a_r6_off_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(offQ))
    else $error("offset changed outside completion");

  // R6: accumulator saturates at the top
  a_r6_sat_high: assert property (@(posedge clk) disable iff (!rstN)
    (strb.winStep && accQ == OFF_MAX && offDir) |=> accQ == OFF_MAX)
    else $error("accumulator wrapped");

  // R7: calibration request survives everything but completion or a write
  a_r7_cal_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (calQ && !strb.commit && !modeWr) |=> calQ)
    else $error("calibration request lost");

  // R9 / R10: completion clears both request bits
  a_r9_commit_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (!calQ && !ovrQ))
    else $error("request bits not cleared");
endmodule

// File: rtl/wake_cal_ctrl.sv
module wake_cal_ctrl
  import wake_cal_pkg::*;
#(
  parameter int TICK_DIV    = 1024,
  parameter int SLEEP_TICKS = 10,
  parameter int CAL_TICKS   = 3600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineIn,
  input  logic       sigAbove,
  input  logic       offDir,
  input  logic       modeWr,
  input  logic       modeCalIn,
  input  logic       modeOvrIn,
  input  logic [2:0] modeCodeIn,
  output logic       wakeLow,
  output logic       countEn,
  output logic [7:0] offsetOut,
  output logic       calPending,
  output logic       ovrPending,
  output logic [2:0] threshCode
);
  logic        tick;
  win_strobe_t strb;
  win_status_t stat;

  wake_cal_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rstN(rstN), .tick(tick)
  );

  wake_cal_fsm u_fsm (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .sigAbove(sigAbove),
    .stat(stat), .strb(strb), .countEn(countEn)
  );

  wake_cal_dp #(.SLEEP_TICKS(SLEEP_TICKS), .CAL_TICKS(CAL_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .sigAbove(sigAbove),
    .offDir(offDir), .tick(tick), .strb(strb), .modeWr(modeWr),
    .modeCalIn(modeCalIn), .modeOvrIn(modeOvrIn), .modeCodeIn(modeCodeIn),
    .stat(stat), .wakeLow(wakeLow), .offsetOut(offsetOut),
    .calPending(calPending), .ovrPending(ovrPending), .threshCode(threshCode)
  );
endmodule

// File: tb/wake_cal_ctrl_bench.sv
module wake_cal_ctrl_bench;
  localparam int SL = 5;
  localparam int CT = 150;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineIn = 1'b1, sigAbove = 1'b0, offDir = 1'b0;
  logic modeWr = 1'b0, modeCalIn = 1'b0, modeOvrIn = 1'b0;
  logic [2:0] modeCodeIn = 3'd0;
  logic wakeLow, countEn, calPending, ovrPending;
  logic [7:0] offsetOut;
  logic [2:0] threshCode;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model state
  int mState = 0;  // 0 run, 1 sleep, 2 window, 3 done
  int mLow = 0, mCc = 0, mAcc = 0, mOff = 0, mCode = 7;
  bit mCal = 0, mOvr = 0, mWake = 0;

  always #10 clk = ~clk;

  wake_cal_ctrl #(.TICK_DIV(1), .SLEEP_TICKS(SL), .CAL_TICKS(CT)) u_wake_cal_ctrl (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .sigAbove(sigAbove), .offDir(offDir),
    .modeWr(modeWr), .modeCalIn(modeCalIn), .modeOvrIn(modeOvrIn), .modeCodeIn(modeCodeIn),
    .wakeLow(wakeLow), .countEn(countEn), .offsetOut(offsetOut),
    .calPending(calPending), .ovrPending(ovrPending), .threshCode(threshCode)
  );

  function automatic int sat8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R2 countEn", int'(countEn), int'(mState == 0));
    check("R1 wakeLow", int'(wakeLow), int'(mWake));
    check("R6 offset", int'($signed(offsetOut)), mOff);
    check("R7 calPending", int'(calPending), int'(mCal));
    check("R9 ovrPending", int'(ovrPending), int'(mOvr));
    check("R4 threshCode", int'(threshCode), mCode);
  endtask

  task automatic modelStep(input bit l, a, d, w, wc, wo, input int wcode);
    bit quiet, ql, commit;
    int ns, st;
    quiet = !l && !a;
    ql = (mLow == SL);
    commit = 0;
    ns = mState;
    case (mState)
      0: begin
        if (mCal && (mOvr ? !a : (quiet && ql))) begin ns = 2; mAcc = 0; mCc = 0; end
        else if (!mCal && quiet && ql) ns = 1;
      end
      1: if (l) ns = 0;
      2: begin
        if (a || (!mOvr && l)) begin ns = 0; mAcc = 0; mCc = 0; end
        else begin
          st = sat8(mAcc + (d ? 1 : -1));
          if (mCc == CT - 1) begin commit = 1; mOff = st; ns = 3; end
          else begin mAcc = st; mCc++; end
        end
      end
      default: if (l) ns = 0;
    endcase
    if (!quiet) mLow = 0;
    else if (mLow < SL) mLow++;
    if (w) begin
      mCal = wc; mOvr = wo;
      if (wcode != 0) mCode = wcode;
    end
    if (commit) begin mCal = 0; mOvr = 0; end
    mWake = l && a;
    mState = ns;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic drive(input bit l, a, d, input bit w = 0, wc = 0, wo = 0,
                       input int wcode = 0);
    compareAll();
    lineIn = l; sigAbove = a; offDir = d;
    modeWr = w; modeCalIn = wc; modeOvrIn = wo; modeCodeIn = 3'(wcode);
    modelStep(l, a, d, w, wc, wo, wcode);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int expOff, seedDummy;
    seedDummy = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    check("R2 reset countEn", int'(countEn), 1);
    check("R4 reset code", int'(threshCode), 7);
    check("R6 reset offset", int'(offsetOut), 0);
    check("R10 reset cal", int'(calPending), 0);

    // R1 wake
    drive(1, 1, 0);
    check("R1 wake on", int'(wakeLow), 1);
    drive(0, 1, 0);
    check("R1 wake off line low", int'(wakeLow), 0);
    drive(1, 0, 0);
    check("R1 wake off below", int'(wakeLow), 0);

    // R4 code writes
    drive(1, 0, 0, 1, 0, 0, 0);
    check("R4 code zero ignored", int'(threshCode), 7);
    drive(1, 0, 0, 1, 0, 0, 3);
    check("R4 code loaded", int'(threshCode), 3);

    // R2 / R3 sleep boundary
    for (int i = 0; i < SL; i++) drive(0, 0, 0);
    check("R2 not asleep at limit", int'(countEn), 1);
    drive(0, 0, 0);
    check("R2 asleep past limit", int'(countEn), 0);
    drive(0, 0, 0);
    check("R2 sleep holds", int'(countEn), 0);
    drive(1, 0, 0);
    check("R3 wake from sleep", int'(countEn), 1);

    // R5 / R6 positive saturation
    drive(1, 0, 0, 1, 1, 0, 0);
    check("R10 cal written", int'(calPending), 1);
    for (int i = 0; i < SL + 1; i++) drive(0, 0, 1);
    check("R5 window opened", int'(countEn), 0);
    for (int i = 0; i < CT - 1; i++) drive(0, 0, 1);
    check("R6 offset before end", int'(offsetOut), 0);
    check("R6 cal before end", int'(calPending), 1);
    drive(0, 0, 1);
    check("R6 positive saturation", int'($signed(offsetOut)), 127);
    check("R6 cal cleared", int'(calPending), 0);
    for (int i = 0; i < 10; i++) drive(0, 0, 0);
    check("R8 stays low power", int'(countEn), 0);
    drive(1, 0, 0);
    check("R8 resume on line high", int'(countEn), 1);

    // R6 negative saturation
    drive(1, 0, 0, 1, 1, 0, 0);
    for (int i = 0; i < SL + 1 + CT; i++) drive(0, 0, 0);
    check("R6 negative saturation", int'($signed(offsetOut)), -128);
    drive(1, 0, 0);

    // R7 abort and restart
    drive(1, 0, 0, 1, 1, 0, 0);
    for (int i = 0; i < SL + 1 + 50; i++) drive(0, 0, 0);
    drive(1, 0, 0);
    check("R7 abort returns to run", int'(countEn), 1);
    check("R7 cal still pending", int'(calPending), 1);
    for (int i = 0; i < SL + 1 + CT; i++) drive(0, 0, 1);
    check("R7 restart from zero", int'($signed(offsetOut)), 127);
    drive(1, 0, 0);

    // R9 override with line high
    drive(1, 0, 0, 1, 1, 1, 2);
    check("R10 ovr written", int'(ovrPending), 1);
    check("R4 code two", int'(threshCode), 2);
    drive(1, 0, 0);
    check("R9 window opens line high", int'(countEn), 0);
    expOff = 0;
    for (int i = 0; i < CT; i++) begin
      expOff = sat8(expOff + ((i < 100) ? 1 : -1));
      drive(1, 0, (i < 100));
    end
    check("R9 override result", int'($signed(offsetOut)), expOff);
    check("R9 ovr cleared", int'(ovrPending), 0);
    drive(1, 0, 0);
    check("R8 resume after override", int'(countEn), 1);

    // random segments against the model
    for (int s = 0; s < 200; s++) begin
      bit l, a;
      int len;
      l = ($urandom % 3 == 0);
      a = ($urandom % 5 == 0);
      len = $urandom_range(1, 300);
      for (int c = 0; c < len; c++) begin
        if ($urandom % 150 == 0)
          drive(l, a, $urandom % 2, 1, $urandom % 2, ($urandom % 4 == 0), $urandom % 8);
        else
          drive(l, a, $urandom % 2);
      end
    end
    compareAll();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule